// File: doc/BRIEF.md
# Time-Slotted Shared RAM Arbiter

This block places one single-port data RAM behind a four-entry slot wheel and shares it among four requesters: a filter engine, a monitor/trace port, a DSP coprocessor and a host CPU. The wheel advances once per clock. Slot 0 is held for the filter engine and slot 2 for the host. The two odd slots belong to the coprocessor. The owner of a slot is granted whenever it requests, so the filter engine, host and coprocessor never contend with one another. When an owner leaves its slot idle, the host is offered that slot first and the monitor port second. The monitor therefore only ever uses cycles that nobody else wanted.

Only one access reaches the RAM per cycle. Writes are committed at the clock edge that ends the grant cycle. Read data is returned exactly one cycle after the grant, on a shared data bus. A valid strobe goes back only to the requester that was granted. The coprocessor is limited to the lower part of the RAM, below a configurable word address. An access above that limit is blocked and raises a sticky violation flag. The host and the coprocessor exchange data through the region they can both reach.

Top module: `slot_ram_arbiter`

## Requirements
- R1: After reset `slot_o` is 0 and then counts 0,1,2,3,0,... one step per clock. While reset is high, `gnt_o`, `rvalid_o` and `cp_viol_o` are all 0.
- R2: In slot 0 a filter request is always granted (`gnt_o[0]`). The filter engine is never granted in any other slot.
- R3: In slot 2 a host request is always granted (`gnt_o[3]`).
- R4: In slots 1 and 3 a coprocessor request is always granted (`gnt_o[2]`). The coprocessor is never granted in slot 0 or slot 2.
- R5: When the slot owner is not requesting, the host is granted if it requests, otherwise the monitor is (`gnt_o[1]`). At most one grant bit is set in any cycle. A requester that is not granted causes no RAM access.
- R6: A coprocessor access at word address CP_LIMIT (default 768) or above is blocked: its write leaves the RAM unchanged and its read returns all zeros.
- R7: The cycle after a blocked coprocessor grant, `cp_viol_o` goes to 1. It then stays at 1 until reset.
- R8: A granted read raises, one cycle later, the `rvalid_o` bit of the same requester, with the data on `rdata_o`. The bit order is 0 filter, 1 monitor, 2 coprocessor, 3 host, and is the same as for `gnt_o`. Writes raise no valid bit.
- R9: A granted, unblocked write is visible to any later read of that address by any requester, including a read in the very next cycle.
- R10: An access by any requester at word address DEPTH (default 1280) or above drops its write and reads back zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_req | input | 1 | Filter engine access request |
| flt_we | input | 1 | Filter engine write (1) or read (0) |
| flt_addr | input | ADDR_W | Filter engine word address |
| flt_wdata | input | DATA_W | Filter engine write data |
| mon_req | input | 1 | Monitor port access request |
| mon_we | input | 1 | Monitor port write (1) or read (0) |
| mon_addr | input | ADDR_W | Monitor port word address |
| mon_wdata | input | DATA_W | Monitor port write data |
| cp_req | input | 1 | Coprocessor access request |
| cp_we | input | 1 | Coprocessor write (1) or read (0) |
| cp_addr | input | ADDR_W | Coprocessor word address |
| cp_wdata | input | DATA_W | Coprocessor write data |
| hst_req | input | 1 | Host access request |
| hst_we | input | 1 | Host write (1) or read (0) |
| hst_addr | input | ADDR_W | Host word address |
| hst_wdata | input | DATA_W | Host write data |
| gnt_o | output | 4 | Grant this cycle, one bit per requester |
| rvalid_o | output | 4 | Read data valid, one bit per requester |
| rdata_o | output | DATA_W | Read data, shared by all requesters |
| slot_o | output | 2 | Current slot of the wheel |
| cp_viol_o | output | 1 | Sticky coprocessor window violation |

## Verification
The bench aims its stimulus at the edges of the coprocessor window: addresses just below, at and just above CP_LIMIT, and addresses past DEPTH. A design with an off-by-one window compare would either corrupt word 768 or zero a legal read of word 767. Dense traffic to a handful of addresses produces read-after-write in consecutive cycles, which catches a read port that returns stale data or a write committed a cycle late. The random request mix keeps owners idle in many slots, so a wheel that let the monitor beat the host, or let the filter or coprocessor claim a slot it does not own, shows up as a wrong grant. Valid strobes routed to the wrong requester show up as well. A reset near the end checks that the violation flag really clears.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;
  localparam int NUM_REQ = 4;
  localparam int SLOT_W  = 2;

  // requester index, shared by gnt_o and rvalid_o bit positions
  localparam int RQ_FLT = 0;
  localparam int RQ_MON = 1;
  localparam int RQ_CP  = 2;
  localparam int RQ_HST = 3;

  // owner of a wheel position; odd positions go to the coprocessor
  function automatic int slot_owner(logic [SLOT_W-1:0] s);
    if (s == 2'd0)      return RQ_FLT;
    else if (s == 2'd2) return RQ_HST;
    else                return RQ_CP;
  endfunction
endpackage

// File: rtl/slot_wheel.sv
module slot_wheel
  import slot_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  output logic [SLOT_W-1:0] slot
);
  always_ff @(posedge clk) begin
    if (rst) slot <= '0;
    else     slot <= slot + 1'b1;
  end
endmodule

// File: rtl/slot_grant.sv
module slot_grant
  import slot_arb_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int DATA_W   = 32,
  parameter int DEPTH    = 1280,
  parameter int CP_LIMIT = 768
) (
  input  logic                        rst,
  input  logic [SLOT_W-1:0]           slot,
  input  logic [NUM_REQ-1:0]          req,
  input  logic [NUM_REQ-1:0]          we,
  input  logic [NUM_REQ*ADDR_W-1:0]   addr_flat,
  input  logic [NUM_REQ*DATA_W-1:0]   wdata_flat,
  output logic [NUM_REQ-1:0]          gnt,
  output logic                        acc_we,
  output logic                        acc_re,
  output logic                        acc_block,
  output logic                        cp_oow,
  output logic [ADDR_W-1:0]           acc_addr,
  output logic [DATA_W-1:0]           acc_wdata
);
  int owner;
  logic any_gnt;
  logic sel_we;
  logic past_depth;

  always_comb begin
    owner = slot_owner(slot);
    gnt   = '0;
    if (!rst) begin
      if (req[owner])       gnt[owner]  = 1'b1;
      else if (req[RQ_HST]) gnt[RQ_HST] = 1'b1;
      else if (req[RQ_MON]) gnt[RQ_MON] = 1'b1;
    end
  end

  // one-hot select of the granted request fields
  always_comb begin
    acc_addr  = '0;
    acc_wdata = '0;
    sel_we    = 1'b0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (gnt[i]) begin
        acc_addr  = addr_flat[i*ADDR_W +: ADDR_W];
        acc_wdata = wdata_flat[i*DATA_W +: DATA_W];
        sel_we    = we[i];
      end
    end
  end

  always_comb begin
    any_gnt    = |gnt;
    past_depth = 32'(acc_addr) >= DEPTH;
    cp_oow     = gnt[RQ_CP] && (32'(acc_addr) >= CP_LIMIT);
    acc_block  = past_depth || cp_oow;
    acc_we     = any_gnt && sel_we && !acc_block;
    acc_re     = any_gnt && !sel_we && !acc_block;
  end
endmodule

// File: rtl/shared_ram.sv
module shared_ram #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 11,
  parameter int DEPTH  = 1280
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/slot_ram_arbiter.sv
module slot_ram_arbiter
  import slot_arb_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 11,
  parameter int DEPTH    = 1280,
  parameter int CP_LIMIT = 768
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flt_req,
  input  logic              flt_we,
  input  logic [ADDR_W-1:0] flt_addr,
  input  logic [DATA_W-1:0] flt_wdata,
  input  logic              mon_req,
  input  logic              mon_we,
  input  logic [ADDR_W-1:0] mon_addr,
  input  logic [DATA_W-1:0] mon_wdata,
  input  logic              cp_req,
  input  logic              cp_we,
  input  logic [ADDR_W-1:0] cp_addr,
  input  logic [DATA_W-1:0] cp_wdata,
  input  logic              hst_req,
  input  logic              hst_we,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic [DATA_W-1:0] hst_wdata,
  output logic [3:0]        gnt_o,
  output logic [3:0]        rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [1:0]        slot_o,
  output logic              cp_viol_o
);
  logic [SLOT_W-1:0]        slot;
  logic [NUM_REQ-1:0]       req, we, gnt;
  logic [NUM_REQ*ADDR_W-1:0] addr_flat;
  logic [NUM_REQ*DATA_W-1:0] wdata_flat;
  logic                     acc_we, acc_re, acc_block, cp_oow;
  logic [ADDR_W-1:0]        acc_addr;
  logic [DATA_W-1:0]        acc_wdata, ram_q;
  logic [NUM_REQ-1:0]       rvalid_q;
  logic                     blank_q, viol_q;

  assign req        = {hst_req, cp_req, mon_req, flt_req};
  assign we         = {hst_we, cp_we, mon_we, flt_we};
  assign addr_flat  = {hst_addr, cp_addr, mon_addr, flt_addr};
  assign wdata_flat = {hst_wdata, cp_wdata, mon_wdata, flt_wdata};

  slot_wheel u_wheel (
    .clk  (clk),
    .rst  (rst),
    .slot (slot)
  );

  slot_grant #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .DEPTH    (DEPTH),
    .CP_LIMIT (CP_LIMIT)
  ) u_grant (
    .rst        (rst),
    .slot       (slot),
    .req        (req),
    .we         (we),
    .addr_flat  (addr_flat),
    .wdata_flat (wdata_flat),
    .gnt        (gnt),
    .acc_we     (acc_we),
    .acc_re     (acc_re),
    .acc_block  (acc_block),
    .cp_oow     (cp_oow),
    .acc_addr   (acc_addr),
    .acc_wdata  (acc_wdata)
  );

  shared_ram #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH)
  ) u_ram (
    .clk   (clk),
    .we    (acc_we),
    .re    (acc_re),
    .addr  (acc_addr),
    .wdata (acc_wdata),
    .rdata (ram_q)
  );

  // return path: strobe follows the grant by one cycle, blocked reads blanked
  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= '0;
      blank_q  <= 1'b0;
      viol_q   <= 1'b0;
    end else begin
      rvalid_q <= gnt & ~we;
      blank_q  <= acc_block;
      if (cp_oow) viol_q <= 1'b1;
    end
  end

  assign gnt_o     = gnt;
  assign rvalid_o  = rvalid_q;
  assign rdata_o   = blank_q ? '0 : ram_q;
  assign slot_o    = slot;
  assign cp_viol_o = viol_q;
endmodule

// File: rtl/slot_ram_arbiter_chk.sv
module slot_ram_arbiter_chk #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 11,
  parameter int CP_LIMIT = 768
) (
  input logic              clk,
  input logic              rst,
  input logic              flt_req,
  input logic              flt_we,
  input logic              mon_req,
  input logic              mon_we,
  input logic              cp_req,
  input logic              cp_we,
  input logic [ADDR_W-1:0] cp_addr,
  input logic              hst_req,
  input logic              hst_we,
  input logic [3:0]        gnt_o,
  input logic [3:0]        rvalid_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic [1:0]        slot_o,
  input logic              cp_viol_o
);
  logic [3:0] we_vec;
  assign we_vec = {hst_we, cp_we, mon_we, flt_we};

  a_r1_slot_step: assert property (@(posedge clk) disable iff (rst)
    !rst |=> slot_o == $past(slot_o) + 2'd1);
  a_r2_flt_slot: assert property (@(posedge clk) disable iff (rst)
    gnt_o[0] |-> slot_o == 2'd0);
  a_r2_flt_owner: assert property (@(posedge clk) disable iff (rst)
    (slot_o == 2'd0 && flt_req) |-> gnt_o[0]);
  a_r3_hst_owner: assert property (@(posedge clk) disable iff (rst)
    (slot_o == 2'd2 && hst_req) |-> gnt_o[3]);
  a_r4_cp_slot: assert property (@(posedge clk) disable iff (rst)
    gnt_o[2] |-> slot_o[0]);
  a_r4_cp_owner: assert property (@(posedge clk) disable iff (rst)
    (slot_o[0] && cp_req) |-> gnt_o[2]);
  a_r5_one_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_o));
  a_r5_mon_last: assert property (@(posedge clk) disable iff (rst)
    gnt_o[1] |-> (mon_req && !hst_req));
  a_r6_blank_read: assert property (@(posedge clk) disable iff (rst)
    (gnt_o[2] && !cp_we && 32'(cp_addr) >= CP_LIMIT) |=> rdata_o == '0);
  a_r7_viol_set: assert property (@(posedge clk) disable iff (rst)
    (gnt_o[2] && 32'(cp_addr) >= CP_LIMIT) |=> cp_viol_o);
  a_r7_viol_sticky: assert property (@(posedge clk) disable iff (rst)
    cp_viol_o |=> cp_viol_o);
  a_r8_latency: assert property (@(posedge clk) disable iff (rst)
    !rst |=> rvalid_o == $past(gnt_o & ~we_vec));
  a_r8_one_valid: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rvalid_o));
endmodule

bind slot_ram_arbiter slot_ram_arbiter_chk #(
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .CP_LIMIT (CP_LIMIT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .flt_req   (flt_req),
  .flt_we    (flt_we),
  .mon_req   (mon_req),
  .mon_we    (mon_we),
  .cp_req    (cp_req),
  .cp_we     (cp_we),
  .cp_addr   (cp_addr),
  .hst_req   (hst_req),
  .hst_we    (hst_we),
  .gnt_o     (gnt_o),
  .rvalid_o  (rvalid_o),
  .rdata_o   (rdata_o),
  .slot_o    (slot_o),
  .cp_viol_o (cp_viol_o)
);

// File: tb/tb_slot_ram_arbiter.sv
`timescale 1ns/1ps
module tb_slot_ram_arbiter;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 11;
  localparam int DEPTH    = 1280;
  localparam int CP_LIMIT = 768;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [3:0]        d_req = '0, d_we = '0;
  logic [ADDR_W-1:0] d_addr [4];
  logic [DATA_W-1:0] d_wd   [4];
  logic [3:0]        gnt_o, rvalid_o;
  logic [DATA_W-1:0] rdata_o;
  logic [1:0]        slot_o;
  logic              cp_viol_o;

  slot_ram_arbiter #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH), .CP_LIMIT(CP_LIMIT)) dut (
    .clk(clk), .rst(rst),
    .flt_req(d_req[0]), .flt_we(d_we[0]), .flt_addr(d_addr[0]), .flt_wdata(d_wd[0]),
    .mon_req(d_req[1]), .mon_we(d_we[1]), .mon_addr(d_addr[1]), .mon_wdata(d_wd[1]),
    .cp_req(d_req[2]),  .cp_we(d_we[2]),  .cp_addr(d_addr[2]),  .cp_wdata(d_wd[2]),
    .hst_req(d_req[3]), .hst_we(d_we[3]), .hst_addr(d_addr[3]), .hst_wdata(d_wd[3]),
    .gnt_o(gnt_o), .rvalid_o(rvalid_o), .rdata_o(rdata_o), .slot_o(slot_o),
    .cp_viol_o(cp_viol_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [DATA_W-1:0] model [DEPTH];
  int slot_m = 0;
  logic viol_m = 1'b0;
  logic [3:0] exp_rv = '0;
  logic [DATA_W-1:0] exp_rd = '0;
  string rd_tag = "R8";

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (time %0t)", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] f_grant(int s, logic [3:0] rq);
    int own;
    own = (s == 0) ? 0 : (s == 2) ? 3 : 2;
    if (rq[own]) return 4'(1 << own);
    if (rq[3])   return 4'b1000;
    if (rq[1])   return 4'b0010;
    return 4'b0000;
  endfunction

  function automatic bit f_block(int who, int a);
    return (a >= DEPTH) || (who == 2 && a >= CP_LIMIT);
  endfunction

  // entered and left at a negedge
  task automatic step();
    logic [3:0] g;
    int who, a;
    string gtag;
    chk("R8 rvalid", 64'(rvalid_o), 64'(exp_rv));
    if (exp_rv != 0) chk(rd_tag, 64'(rdata_o), 64'(exp_rd));
    chk("R7 viol", 64'(cp_viol_o), 64'(viol_m));
    chk("R1 slot", 64'(slot_o), 64'(slot_m));
    #1;
    g = f_grant(slot_m, d_req);
    gtag = (slot_m == 0) ? "R2 grant" : (slot_m == 2) ? "R3 grant" : "R4 grant";
    if (g != 0 && !(slot_m == 0 && g[0]) && !(slot_m == 2 && g[3]) && !(slot_m[0] && g[2]))
      gtag = "R5 grant";
    if (g == 0) gtag = "R5 grant";
    chk(gtag, 64'(gnt_o), 64'(g));
    exp_rv = '0;
    if (g != 0) begin
      who = 0;
      for (int i = 0; i < 4; i++) if (g[i]) who = i;
      a = int'(d_addr[who]);
      if (who == 2 && a >= CP_LIMIT) viol_m = 1'b1;
      if (d_we[who]) begin
        if (!f_block(who, a)) model[a] = d_wd[who];
      end else begin
        exp_rv = g;
        if (f_block(who, a)) begin
          exp_rd = '0;
          rd_tag = (a >= DEPTH) ? "R10 blocked read" : "R6 blocked read";
        end else begin
          exp_rd = model[a];
          rd_tag = "R9 read data";
        end
      end
    end
    slot_m = (slot_m + 1) % 4;
    @(negedge clk);
  endtask

  task automatic do_reset();
    d_req = '0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset slot", 64'(slot_o), 0);
    chk("R1 reset gnt", 64'(gnt_o), 0);
    chk("R1 reset rvalid", 64'(rvalid_o), 0);
    chk("R1 reset viol", 64'(cp_viol_o), 0);
    rst = 1'b0;
    slot_m = 0; viol_m = 1'b0; exp_rv = '0;
  endtask

  task automatic set_one(int who, bit w, int a, logic [DATA_W-1:0] d);
    d_req[who] = 1'b1; d_we[who] = w;
    d_addr[who] = ADDR_W'(a); d_wd[who] = d;
  endtask

  function automatic int rand_addr();
    int m;
    m = int'($urandom_range(0, 9));
    if (m < 5) return int'($urandom_range(0, DEPTH - 1));
    if (m < 7) return int'($urandom_range(CP_LIMIT - 2, CP_LIMIT + 1));
    if (m < 8) return int'($urandom_range(DEPTH, (1 << ADDR_W) - 1));
    return int'($urandom_range(0, 7));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4; i++) begin d_addr[i] = '0; d_wd[i] = '0; end
    do_reset();

    // preload every word through the host; it owns every idle slot
    for (int a = 0; a < DEPTH; a++) begin
      d_req = '0;
      set_one(3, 1'b1, a, $urandom());
      step();
    end

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      d_req = 4'($urandom());
      d_we  = 4'($urandom());
      for (int i = 0; i < 4; i++) begin
        d_addr[i] = ADDR_W'(rand_addr());
        d_wd[i]   = $urandom();
      end
      step();
    end

    // directed: flag clears on reset, then window edges and back-to-back RAW
    do_reset();
    d_req = '0; set_one(0, 1'b1, 5, 32'hA5A5_0001); step();            // slot0 filter write
    d_req = '0; set_one(2, 1'b0, CP_LIMIT - 1, '0); step();            // slot1 cp legal read
    d_req = '0; set_one(3, 1'b0, 5, '0); step();                       // slot2 host RAW
    d_req = '0; set_one(2, 1'b1, CP_LIMIT, 32'hDEAD_BEEF); step();     // slot3 cp blocked write R6
    d_req = '0; set_one(1, 1'b0, CP_LIMIT, '0); step();                // slot0 monitor reads old R6
    d_req = '0; set_one(2, 1'b0, CP_LIMIT, '0);
    set_one(1, 1'b0, 3, '0); step();                                   // slot1 cp blocked read, mon waits
    d_req = '0; set_one(1, 1'b1, DEPTH + 3, 32'h1); step();            // R10 write dropped
    d_req = '0; set_one(1, 1'b0, DEPTH + 3, '0); step();               // R10 read zero
    d_req = '0; set_one(3, 1'b0, 1, '0); set_one(1, 1'b0, 2, '0); step(); // R5 host over monitor
    d_req = '0; step(); step();
    chk("R7 viol held", 64'(cp_viol_o), 1);
    do_reset();
    d_req = '0; step();

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule